// File: doc/BRIEF.md
# Multithread Fetch Thread Selector

This block decides, once per cycle, which hardware thread of a multithreaded core may use the instruction fetch path. Each thread reports a 3-bit fetch state, and an active mask says which threads currently exist. From these the block produces a one-hot decision: a `pick_valid` flag and the chosen thread number. A static mode input selects between two policies. The first is a rotating round-robin over an ordered list of thread numbers. The second is a fixed policy that only ever considers the lowest-numbered active thread.

The decision leaves on a valid/ready pair. `pick_valid` and `pick_tid` are combinational from the present inputs and the stored order. The consumer raises `pick_ready` in a cycle where it takes the thread. The stored order changes only at a clock edge where `pick_valid` and `pick_ready` are both high. Holding `pick_ready` low is back-pressure: the order is frozen, and as long as the inputs do not change the same thread stays offered. Because `pick_valid` is not registered, it may drop or change thread when the states or the mask change, even if no acceptance has taken place. `drain_hold` withholds every grant, for example while the pipeline empties.

Top module: `fetch_thread_picker`

## Requirements
- R1: Each thread's state field occupies bits [3*i+2:3*i] of `thr_state`. Codes 0 (running), 1 (line fill finished) and 2 (idle) make a thread eligible. Codes 3 to 7 (blocked, squashing, waiting for memory, waiting to retry, trap pending) never allow a grant.
- R2: A thread whose bit in `thr_active` is 0 is treated exactly like an ineligible thread.
- R3: In round-robin mode (`mode_rr`=1, `NUM_THREADS`>1), the thread granted is the first eligible, active thread found when the order list is walked from its head.
- R4: When a round-robin grant is accepted, that thread is removed from its place and appended at the tail. The other threads keep their relative order.
- R5: After reset the order list holds 0, 1, ..., `NUM_THREADS`-1 from head to tail.
- R6: When no thread qualifies, `pick_valid` is 0 and `pick_tid` is 0.
- R7: In single mode (`mode_rr`=0), only the lowest-numbered active thread is considered. It is granted only if its state is eligible. Accepting such a grant leaves the order list unchanged.
- R8: When `NUM_THREADS` is 1, the single-mode rule applies whatever the value of `mode_rr`.
- R9: While `drain_hold` is 1, `pick_valid` is 0, and the order list does not change even if `pick_ready` is high.
- R10: The order list changes only at a clock edge where `pick_valid` and `pick_ready` are both 1. With `pick_ready` low and the inputs held steady, the same thread stays offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rr | input | 1 | Static policy select: 1 round-robin, 0 single |
| thr_state | input | 3*NUM_THREADS | Packed per-thread fetch state codes |
| thr_active | input | NUM_THREADS | Per-thread active mask |
| drain_hold | input | 1 | Suppresses all grants |
| pick_valid | output | 1 | A thread is offered this cycle |
| pick_tid | output | TID_W | Offered thread number, 0 when not valid |
| pick_ready | input | 1 | Consumer accepts the offered thread |

## Verification
The bench builds two instances. The first uses `NUM_THREADS`=4. This is wide enough that a grant from the middle of the order list, a skipped inactive head, and a rotation of several steps can all be observed through `pick_tid`. The second uses `NUM_THREADS`=1, with `mode_rr` held high, so that the forced single-thread rule can be reached. The contents of the order list are never read directly. They are inferred from which thread each later round-robin grant picks, including a grant made after single-mode and drained cycles that must not have disturbed the list.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    THR_RUN        = 3'd0,
    THR_FILL_DONE  = 3'd1,
    THR_IDLE       = 3'd2,
    THR_BLOCKED    = 3'd3,
    THR_SQUASH     = 3'd4,
    THR_MEM_WAIT   = 3'd5,
    THR_RETRY_WAIT = 3'd6,
    THR_TRAP       = 3'd7
  } thr_state_e;

  // R1: the three states from which fetch may proceed
  function automatic logic can_fetch(input logic [STATE_W-1:0] code);
    return (code == THR_RUN) || (code == THR_FILL_DONE) || (code == THR_IDLE);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*fts_pkg::STATE_W-1:0] thr_state,
  input  logic [NUM_THREADS-1:0]                  thr_active,
  output logic [NUM_THREADS-1:0]                  elig
);
  localparam int SW = fts_pkg::STATE_W;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    // R1, R2
    assign elig[g] = thr_active[g] && fts_pkg::can_fetch(thr_state[g*SW +: SW]);
  end
endmodule

// File: rtl/fts_order_list.sv
module fts_order_list #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd,
  input  logic [TID_W-1:0]             upd_pos,
  output logic [NUM_THREADS*TID_W-1:0] order_flat
);
  logic [TID_W-1:0] slot   [NUM_THREADS];
  logic [TID_W-1:0] slot_n [NUM_THREADS];
  logic [TID_W-1:0] moved;

  assign moved = slot[upd_pos];

  // R4: slots at and after the granted position shift toward the head,
  // and the granted thread lands on the tail
  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      slot_n[i] = slot[i];
      if (upd && (i >= int'(upd_pos))) begin
        if (i == NUM_THREADS - 1) slot_n[i] = moved;
        else                      slot_n[i] = slot[(i + 1) % NUM_THREADS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) slot[i] <= TID_W'(i);  // R5
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) slot[i] <= slot_n[i];
    end
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_flat
    assign order_flat[g*TID_W +: TID_W] = slot[g];
  end
endmodule

// File: rtl/fts_rr_scan.sv
module fts_rr_scan #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS*TID_W-1:0] order_flat,
  input  logic [NUM_THREADS-1:0]       elig,
  output logic                         hit,
  output logic [TID_W-1:0]             hit_pos,
  output logic [TID_W-1:0]             hit_tid
);
  // R3: walk from the head, take the first eligible entry
  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    hit_tid = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (!hit && elig[order_flat[i*TID_W +: TID_W]]) begin
        hit     = 1'b1;
        hit_pos = TID_W'(i);
        hit_tid = order_flat[i*TID_W +: TID_W];
      end
    end
  end
endmodule

// File: rtl/fts_single_pick.sv
module fts_single_pick #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0] thr_active,
  input  logic [NUM_THREADS-1:0] elig,
  output logic                   hit,
  output logic [TID_W-1:0]       hit_tid
);
  logic             found;
  logic [TID_W-1:0] first;

  // R7: the lowest-numbered active thread is the only candidate
  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (!found && thr_active[i]) begin
        found = 1'b1;
        first = TID_W'(i);
      end
    end
  end

  assign hit     = found && elig[first];
  assign hit_tid = first;
endmodule

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker #(
  parameter int NUM_THREADS = 4,
  localparam int SW    = fts_pkg::STATE_W,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_rr,
  input  logic [NUM_THREADS*SW-1:0] thr_state,
  input  logic [NUM_THREADS-1:0]    thr_active,
  input  logic                      drain_hold,
  output logic                      pick_valid,
  output logic [TID_W-1:0]          pick_tid,
  input  logic                      pick_ready
);
  localparam bit MULTI = (NUM_THREADS > 1);

  logic [NUM_THREADS-1:0]       elig;
  logic [NUM_THREADS*TID_W-1:0] order_flat;
  logic                         rr_hit, st_hit, rr_eff, accept_rr;
  logic [TID_W-1:0]             rr_pos, rr_tid, st_tid;

  fts_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .thr_state (thr_state),
    .thr_active(thr_active),
    .elig      (elig)
  );

  fts_order_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (accept_rr),
    .upd_pos   (rr_pos),
    .order_flat(order_flat)
  );

  fts_rr_scan #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_scan (
    .order_flat(order_flat),
    .elig      (elig),
    .hit       (rr_hit),
    .hit_pos   (rr_pos),
    .hit_tid   (rr_tid)
  );

  fts_single_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_single (
    .thr_active(thr_active),
    .elig      (elig),
    .hit       (st_hit),
    .hit_tid   (st_tid)
  );

  // R8: a lone thread always follows the single-mode rule
  assign rr_eff = MULTI && mode_rr;

  // R9: drain suppresses the offer; R6: tid forced to 0 when nothing offered
  assign pick_valid = !drain_hold && (rr_eff ? rr_hit : st_hit);
  assign pick_tid   = pick_valid ? (rr_eff ? rr_tid : st_tid) : '0;

  // R10, R7: only an accepted round-robin grant rotates the list
  assign accept_rr = pick_valid && pick_ready && rr_eff;
endmodule

// File: rtl/fts_picker_chk.sv
module fts_picker_chk #(
  parameter int NUM_THREADS = 4,
  localparam int SW    = fts_pkg::STATE_W,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mode_rr,
  input logic [NUM_THREADS*SW-1:0] thr_state,
  input logic [NUM_THREADS-1:0]    thr_active,
  input logic                      drain_hold,
  input logic                      pick_valid,
  input logic [TID_W-1:0]          pick_tid,
  input logic                      pick_ready
);
  logic             any_ok, all_ok;
  logic [TID_W-1:0] low_active;
  logic             low_found;

  always_comb begin
    any_ok     = 1'b0;
    all_ok     = 1'b1;
    low_active = '0;
    low_found  = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (thr_active[i] && thr_state[i*SW +: SW] <= 3'd2) any_ok = 1'b1;
      else                                                all_ok = 1'b0;
      if (!low_found && thr_active[i]) begin
        low_found  = 1'b1;
        low_active = TID_W'(i);
      end
    end
  end

  // R9
  drain_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_hold |-> !pick_valid);

  // R1
  pick_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (thr_state[pick_tid*SW +: SW] <= 3'd2));

  // R2
  pick_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> thr_active[pick_tid]);

  // R6
  none_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ok |-> (!pick_valid && pick_tid == '0));

  // R7, R8
  single_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!mode_rr || NUM_THREADS == 1) && pick_valid) |-> (pick_tid == low_active));

  // R10
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !pick_ready) |=>
      (!($stable(thr_state) && $stable(thr_active) && $stable(drain_hold) && $stable(mode_rr))
       || (pick_valid && $stable(pick_tid))));

  // R4
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rr && NUM_THREADS > 1 && pick_valid && pick_ready) |=>
      (!all_ok || drain_hold || !mode_rr || pick_tid != $past(pick_tid)));
endmodule

bind fetch_thread_picker fts_picker_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_rr   (mode_rr),
  .thr_state (thr_state),
  .thr_active(thr_active),
  .drain_hold(drain_hold),
  .pick_valid(pick_valid),
  .pick_tid  (pick_tid),
  .pick_ready(pick_ready)
);

// File: tb/test_fetch_thread_picker.sv
module test_fetch_thread_picker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_rr = 1'b1;
  logic [11:0] thr_state = '0;
  logic [3:0]  thr_active = 4'hF;
  logic        drain_hold = 1'b0;
  logic        pick_ready = 1'b0;
  logic        pick_valid;
  logic [1:0]  pick_tid;

  logic        s_mode = 1'b1;
  logic [2:0]  s_state = '0;
  logic        s_active = 1'b1;
  logic        s_valid;
  logic [0:0]  s_tid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_thread_picker #(.NUM_THREADS(4)) i_fetch_thread_picker (
    .clk(clk), .rst_n(rst_n), .mode_rr(mode_rr), .thr_state(thr_state),
    .thr_active(thr_active), .drain_hold(drain_hold),
    .pick_valid(pick_valid), .pick_tid(pick_tid), .pick_ready(pick_ready)
  );

  fetch_thread_picker #(.NUM_THREADS(1)) i_fetch_thread_picker_solo (
    .clk(clk), .rst_n(rst_n), .mode_rr(s_mode), .thr_state(s_state),
    .thr_active(s_active), .drain_hold(1'b0),
    .pick_valid(s_valid), .pick_tid(s_tid), .pick_ready(1'b1)
  );

  typedef struct packed {
    logic       rr;
    logic [3:0] act;
    logic [11:0] st;
    logic       drn;
    logic       rdy;
    logic       ev;
    logic [1:0] etid;
  } vec_t;

  // order list tracked by hand in the comments (head first)
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'hF, 12'h000, 1'b0, 1'b1, 1'b1, 2'd0},  // 0123 -> 1230
    '{1'b1, 4'hF, 12'h000, 1'b0, 1'b1, 1'b1, 2'd1},  // -> 2301
    '{1'b1, 4'hF, 12'h000, 1'b0, 1'b0, 1'b1, 2'd2},  // held
    '{1'b1, 4'hF, 12'h0C0, 1'b0, 1'b1, 1'b1, 2'd3},  // t2 blocked -> 2013
    '{1'b1, 4'hB, 12'h000, 1'b0, 1'b1, 1'b1, 2'd0},  // t2 inactive -> 2130
    '{1'b1, 4'hF, 12'h362, 1'b0, 1'b1, 1'b1, 2'd3},  // mixed -> 2103
    '{1'b1, 4'hF, 12'h6DB, 1'b0, 1'b1, 1'b0, 2'd0},  // all blocked
    '{1'b1, 4'hF, 12'h000, 1'b1, 1'b1, 1'b0, 2'd0},  // drain
    '{1'b1, 4'hF, 12'h000, 1'b0, 1'b1, 1'b1, 2'd2},  // -> 1032
    '{1'b0, 4'hF, 12'h000, 1'b0, 1'b1, 1'b1, 2'd0},  // single
    '{1'b0, 4'hC, 12'h000, 1'b0, 1'b1, 1'b1, 2'd2},  // single low active
    '{1'b0, 4'hC, 12'h1C0, 1'b0, 1'b1, 1'b0, 2'd0},  // single first traps
    '{1'b0, 4'h0, 12'h000, 1'b0, 1'b1, 1'b0, 2'd0},  // nothing active
    '{1'b1, 4'hF, 12'h000, 1'b0, 1'b1, 1'b1, 2'd1},  // list untouched -> 0321
    '{1'b1, 4'hF, 12'h006, 1'b0, 1'b1, 1'b1, 2'd3},  // t0 retry wait -> 0213
    '{1'b1, 4'hF, 12'h000, 1'b0, 1'b1, 1'b1, 2'd0}   // -> 2130
  };

  localparam string TAGS [NV] = '{
    "R3 R5 head grant", "R4 rotation", "R10 held offer", "R1 R3 blocked skipped",
    "R2 inactive skipped", "R1 state codes", "R6 none eligible", "R9 drain",
    "R9 R10 list kept", "R7 single mode", "R7 lowest active", "R7 first only",
    "R6 R2 no active", "R7 list untouched", "R1 retry wait", "R4 tail append"
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // reset state: ascending order, head is thread 0
    repeat (2) @(negedge clk);
    #2;
    check("R5 reset valid", int'(pick_valid), 1);
    check("R5 reset tid", int'(pick_tid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode_rr    = VECS[v].rr;
      thr_active = VECS[v].act;
      thr_state  = VECS[v].st;
      drain_hold = VECS[v].drn;
      pick_ready = VECS[v].rdy;
      #2;
      check(TAGS[v], int'(pick_valid), int'(VECS[v].ev));
      check(TAGS[v], int'(pick_tid), int'(VECS[v].etid));
    end

    // R5 R4: after a fresh reset, accepted grants come out ascending
    @(negedge clk);
    pick_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mode_rr = 1'b1; thr_active = 4'hF; thr_state = '0; drain_hold = 1'b0;
    pick_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #2;
      check("R5 R4 ascending after reset", int'(pick_tid), k % 4);
      @(negedge clk);
    end

    // R10: back-pressure then drop readiness, offer stays
    pick_ready = 1'b0;
    #2;
    check("R10 stall offer", int'(pick_tid), 1);
    @(negedge clk);
    #2;
    check("R10 stall offer kept", int'(pick_tid), 1);
    pick_ready = 1'b0;

    // R8: single thread instance ignores round-robin select
    @(negedge clk);
    s_mode = 1'b1; s_state = 3'd2; s_active = 1'b1;
    #2;
    check("R8 solo idle granted", int'(s_valid), 1);
    check("R8 solo tid", int'(s_tid), 0);
    @(negedge clk);
    s_state = 3'd5;
    #2;
    check("R8 solo waiting not granted", int'(s_valid), 0);
    @(negedge clk);
    s_state = 3'd0; s_active = 1'b0;
    #2;
    check("R8 solo inactive not granted", int'(s_valid), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule